// File: doc/BRIEF.md
# Stack Frame Release Sequencer

This block removes a stack frame in several cycles, controlled by one two-halfword instruction. When the instruction is accepted, the block skips the frame's local area by adding a scaled 5-bit word count to the incoming stack pointer. It then restores a sparse set of registers, chosen by a 12-bit mask, from consecutive stack words. It does one restore per cycle, reading memory and writing the register file in the same cycle. At the end it hands back the final stack pointer.

A variant of the same instruction names a register in its low field. After the restores, this variant reads that register and issues a jump to its contents. The read happens after the restores, so a target that was just popped supplies its popped value. Instruction fetch, the register file and the memory are outside the block. The block only drives their ports and expects a memory read to return its data in the same cycle.

Top module: `frame_release`

## Requirements
- R1: A `start` pulse is accepted only while the block is idle and only if `instr_hi[15:6]` equals `10'b0000011001`. Any other pattern leaves the block idle and raises no strobe.
- R2: The stack pointer after the adjust equals `sp_in + (imm << 2)`, where `imm = instr_hi[5:1]` is zero-extended.
- R3: The restore mask has bit 11 = `instr_hi[0]` and bits 10..0 = `instr_lo[15:5]`. Mask bit i selects register number 20 + i.
- R4: The set mask bits are restored from the lowest bit upward, one per cycle. Each restore asserts `mem_rd_en` and `rf_we` and writes `mem_rd_data` to that register. The first address is the adjusted stack pointer and each later address is 4 higher.
- R5: When `instr_lo[4:0]` is zero (plain form) and N mask bits are set, the block stays busy for N+1 cycles. In the last of these cycles it asserts `sp_we` and `done` together, with `sp_out` equal to the adjusted pointer plus 4N.
- R6: When `instr_lo[4:0]` is nonzero (jump form), the block stays busy for N+3 cycles. It asserts `sp_we` in cycle N+1 and reads register `instr_lo[4:0]` in cycle N+2. In cycle N+3 it asserts `pc_we` and `done`, with `pc_out` equal to that register's value after the restores.
- R7: An empty mask performs no restore. Only the pointer write-back (and, in the jump form, the jump) takes place.
- R8: A `start` pulse that arrives while the block is busy is ignored and does not change the run in progress.
- R9: After reset the block is idle, with `busy`, `done`, `rf_we`, `mem_rd_en`, `sp_we` and `pc_we` all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to run the instruction presented |
| instr_hi | input | 16 | First instruction halfword |
| instr_lo | input | 16 | Second instruction halfword |
| sp_in | input | 32 | Stack pointer when the instruction starts |
| busy | output | 1 | Sequence in progress |
| mem_rd_en | output | 1 | Memory word read strobe |
| mem_addr | output | 32 | Memory byte address of the word read |
| mem_rd_data | input | 32 | Word returned in the same cycle |
| rf_we | output | 1 | Register file write strobe |
| rf_waddr | output | 5 | Register written |
| rf_wdata | output | 32 | Value written |
| rf_rd_addr | output | 5 | Register read for the jump target |
| rf_rd_data | input | 32 | Value of `rf_rd_addr` |
| sp_we | output | 1 | Final stack pointer strobe |
| sp_out | output | 32 | Final stack pointer |
| pc_we | output | 1 | Jump strobe |
| pc_out | output | 32 | Jump target |
| done | output | 1 | Last cycle of the sequence |

## Verification
The assertions assume two things about the inputs. `mem_rd_data` is valid in the same cycle as `mem_addr`, and the register file shows a write on its read port from the next cycle on. The bench models the memory as a combinational function of the address and writes its register model on the clock edge, so both assumptions hold. The assertions also assume that reset is held for at least one clock edge, and the bench holds it for several. The bench applies `start` at the falling edge and only with well-formed halfwords. The exceptions are the malformed-opcode case and the restart attempt, which are the stimuli R1 and R8 describe.

// File: rtl/frame_release_pkg.sv
package frame_release_pkg;

    localparam int IMM_W   = 5;
    localparam int LIST_W  = 12;
    localparam int REG_AW  = 5;
    localparam int IDX_W   = $clog2(LIST_W);
    localparam int OPC_W   = 10;
    localparam logic [OPC_W-1:0] OPC_VAL = 10'b0000011001;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_POP,
        ST_FIN,
        ST_SPWB,
        ST_TGT,
        ST_JMP
    } seq_state_e;

    typedef struct packed {
        logic              ok;
        logic [IMM_W-1:0]  imm;
        logic [LIST_W-1:0] mask;
        logic [REG_AW-1:0] jreg;
    } frame_cmd_t;

    function automatic logic is_jump(input frame_cmd_t c);
        return c.jreg != '0;
    endfunction

endpackage

// File: rtl/frame_release_decode.sv
module frame_release_decode
    import frame_release_pkg::*;
(
    input  logic [15:0] hw_first,
    input  logic [15:0] hw_second,
    output frame_cmd_t  cmd
);
    always_comb begin
        cmd.ok   = (hw_first[15:16-OPC_W] == OPC_VAL);
        cmd.imm  = hw_first[IMM_W:1];
        cmd.mask = {hw_first[0], hw_second[15:REG_AW]};
        cmd.jreg = hw_second[REG_AW-1:0];
    end
endmodule

// File: rtl/frame_release_pick.sv
module frame_release_pick #(
    parameter int W  = 12,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  mask_in,
    output logic [W-1:0]  pick_oh,
    output logic [IW-1:0] pick_idx,
    output logic [W-1:0]  mask_next,
    output logic          last
);
    always_comb begin
        pick_oh   = mask_in & (~mask_in + W'(1));
        mask_next = mask_in & ~pick_oh;
        last      = (mask_next == '0);
    end

    always_comb begin
        pick_idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (mask_in[i]) pick_idx = IW'(i);
        end
    end
endmodule

// File: rtl/frame_release.sv
module frame_release
    import frame_release_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int REG_BASE   = 20,
    parameter int WORD_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [15:0]       instr_hi,
    input  logic [15:0]       instr_lo,
    input  logic [XLEN-1:0]   sp_in,
    output logic              busy,
    output logic              mem_rd_en,
    output logic [XLEN-1:0]   mem_addr,
    input  logic [XLEN-1:0]   mem_rd_data,
    output logic              rf_we,
    output logic [REG_AW-1:0] rf_waddr,
    output logic [XLEN-1:0]   rf_wdata,
    output logic [REG_AW-1:0] rf_rd_addr,
    input  logic [XLEN-1:0]   rf_rd_data,
    output logic              sp_we,
    output logic [XLEN-1:0]   sp_out,
    output logic              pc_we,
    output logic [XLEN-1:0]   pc_out,
    output logic              done
);
    localparam int PAD_W = XLEN - IMM_W - 2;

    frame_cmd_t        cmd;
    seq_state_e        state;
    logic [XLEN-1:0]   sp_q;
    logic [XLEN-1:0]   pc_q;
    logic [LIST_W-1:0] mask_q;
    logic [REG_AW-1:0] jreg_q;
    logic [LIST_W-1:0] pick_oh;
    logic [LIST_W-1:0] mask_next;
    logic [IDX_W-1:0]  pick_idx;
    logic              pick_last;
    logic              accept;

    frame_release_decode u_decode (
        .hw_first  (instr_hi),
        .hw_second (instr_lo),
        .cmd       (cmd)
    );

    frame_release_pick #(.W(LIST_W), .IW(IDX_W)) u_pick (
        .mask_in   (mask_q),
        .pick_oh   (pick_oh),
        .pick_idx  (pick_idx),
        .mask_next (mask_next),
        .last      (pick_last)
    );

    assign accept = start && cmd.ok && (state == ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            sp_q   <= '0;
            pc_q   <= '0;
            mask_q <= '0;
            jreg_q <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (accept) begin
                    sp_q   <= sp_in + {{PAD_W{1'b0}}, cmd.imm, 2'b00};
                    mask_q <= cmd.mask;
                    jreg_q <= cmd.jreg;
                    if (cmd.mask != '0)   state <= ST_POP;
                    else if (is_jump(cmd)) state <= ST_SPWB;
                    else                  state <= ST_FIN;
                end
                ST_POP: begin
                    sp_q   <= sp_q + XLEN'(WORD_BYTES);
                    mask_q <= mask_next;
                    if (pick_last) state <= (jreg_q != '0) ? ST_SPWB : ST_FIN;
                end
                ST_SPWB: state <= ST_TGT;
                ST_TGT: begin
                    pc_q  <= rf_rd_data;
                    state <= ST_JMP;
                end
                ST_FIN:  state <= ST_IDLE;
                ST_JMP:  state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        busy       = (state != ST_IDLE);
        mem_rd_en  = (state == ST_POP);
        mem_addr   = mem_rd_en ? sp_q : '0;
        rf_we      = mem_rd_en;
        rf_waddr   = mem_rd_en ? REG_AW'(REG_BASE) + REG_AW'(pick_idx) : '0;
        rf_wdata   = mem_rd_en ? mem_rd_data : '0;
        rf_rd_addr = (state == ST_TGT) ? jreg_q : '0;
        sp_we      = (state == ST_FIN) || (state == ST_SPWB);
        sp_out     = sp_q;
        pc_we      = (state == ST_JMP);
        pc_out     = pc_q;
        done       = (state == ST_FIN) || (state == ST_JMP);
    end

    // R4: back-to-back restores walk up the stack one word at a time
    a_r4_addr_step: assert property (@(posedge clk) disable iff (rst)
        (rf_we && $past(rf_we)) |-> (mem_addr == $past(mem_addr) + XLEN'(WORD_BYTES)));

    // R4: registers come out in ascending order
    a_r4_order: assert property (@(posedge clk) disable iff (rst)
        (rf_we && $past(rf_we)) |-> (rf_waddr > $past(rf_waddr)));

    // R4: the picker selects exactly one bit that is really in the mask
    a_r4_pick_single: assert property (@(posedge clk) disable iff (rst)
        (mask_q != '0) |-> ($onehot(pick_oh) && ((pick_oh & mask_q) == pick_oh)));

    // R5: the closing pulse always carries a write-back
    a_r5_done_with_write: assert property (@(posedge clk) disable iff (rst)
        done |-> (sp_we || pc_we));

    // R6: the jump follows the pointer write-back by two cycles
    a_r6_jump_spacing: assert property (@(posedge clk) disable iff (rst)
        (sp_we && !done) |=> ##1 (pc_we && done));

    // R8: once running, the block stays busy until its done cycle
    a_r8_hold_busy: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy);

    // R9: an idle block drives no strobe
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !(rf_we || mem_rd_en || sp_we || pc_we || done));

endmodule

// File: tb/frame_release_tb.sv
module frame_release_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] instr_hi = '0;
    logic [15:0] instr_lo = '0;
    logic [31:0] sp_in = '0;
    logic        busy, mem_rd_en, rf_we, sp_we, pc_we, done;
    logic [31:0] mem_addr, mem_rd_data, rf_wdata, rf_rd_data, sp_out, pc_out;
    logic [4:0]  rf_waddr, rf_rd_addr;

    logic [31:0] rf_model [32];
    logic        rf_init = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;
    int wd_cnt   = 0;

    always #10 clk = ~clk;

    function automatic logic [31:0] memf(input logic [31:0] a);
        return {a[15:0] ^ 16'h5A5A, a[31:16] + 16'h0111};
    endfunction

    function automatic logic [31:0] rf_seed(input int i);
        return 32'h4000_0000 + 32'(i) * 32'h100;
    endfunction

    assign mem_rd_data = memf(mem_addr);
    assign rf_rd_data  = rf_model[rf_rd_addr];

    always @(posedge clk) begin
        if (rf_init) begin
            for (int i = 0; i < 32; i++) rf_model[i] <= rf_seed(i);
        end else if (rf_we) begin
            rf_model[rf_waddr] <= rf_wdata;
        end
    end

    frame_release u_dut (
        .clk(clk), .rst(rst), .start(start),
        .instr_hi(instr_hi), .instr_lo(instr_lo), .sp_in(sp_in),
        .busy(busy), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
        .mem_rd_data(mem_rd_data), .rf_we(rf_we), .rf_waddr(rf_waddr),
        .rf_wdata(rf_wdata), .rf_rd_addr(rf_rd_addr), .rf_rd_data(rf_rd_data),
        .sp_we(sp_we), .sp_out(sp_out), .pc_we(pc_we), .pc_out(pc_out),
        .done(done)
    );

    task automatic check(input logic ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        wd_cnt++;
        if (wd_cnt > 100000) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual %0d expected below 100000", wd_cnt);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    // Runs one instruction and checks every restore, the pointer, the jump and the timing.
    task automatic run_frame(input logic [15:0] hi, input logic [15:0] lo,
                             input logic [31:0] sp, input logic poke);
        logic [11:0] mask;
        logic [4:0]  jreg;
        logic [31:0] adj, exp_pc;
        int n, pops, cyc, fin_cyc, bit_i;
        logic jump, saw_done, saw_sp;
        mask = {hi[0], lo[15:5]};
        jreg = lo[4:0];
        jump = (jreg != 0);
        n    = $countones(mask);
        adj  = sp + {25'd0, hi[5:1], 2'b00};
        exp_pc = rf_seed(int'(jreg));
        pops = 0;
        for (int i = 0; i < 12; i++) begin
            if (mask[i]) begin
                if (jump && int'(jreg) == 20 + i) exp_pc = memf(adj + 32'(pops) * 4);
                pops++;
            end
        end
        fin_cyc = jump ? n + 3 : n + 1;

        @(negedge clk);
        rf_init = 1'b1;
        @(negedge clk);
        rf_init  = 1'b0;
        instr_hi = hi;
        instr_lo = lo;
        sp_in    = sp;
        start    = 1'b1;
        @(posedge clk);
        pops = 0; cyc = 0; bit_i = 0; saw_done = 0; saw_sp = 0;
        while (cyc < 60 && !saw_done) begin
            @(negedge clk);
            cyc++;
            start = 1'b0;
            if (poke && cyc == 2) begin
                // R8: a second valid request while busy
                instr_hi = 16'h0640;
                instr_lo = 16'h0000;
                sp_in    = 32'hDEAD_0000;
                start    = 1'b1;
            end
            if (rf_we) begin
                while (bit_i < 12 && !mask[bit_i]) bit_i++;
                check(rf_waddr == 5'(20 + bit_i), "R3", "restored register",
                      32'(rf_waddr), 32'(20 + bit_i));
                check(mem_addr == adj + 32'(pops) * 4, "R4", "restore address",
                      mem_addr, adj + 32'(pops) * 4);
                check(rf_wdata == memf(adj + 32'(pops) * 4), "R4", "restore data",
                      rf_wdata, memf(adj + 32'(pops) * 4));
                check(mem_rd_en, "R4", "read strobe with write", 32'(mem_rd_en), 1);
                bit_i++;
                pops++;
            end
            if (sp_we) begin
                saw_sp = 1;
                check(cyc == n + 1, "R5", "pointer write cycle", 32'(cyc), 32'(n + 1));
                check(sp_out == adj + 32'(n) * 4, "R2", "final pointer",
                      sp_out, adj + 32'(n) * 4);
            end
            if (pc_we) begin
                check(jump && cyc == n + 3, "R6", "jump cycle", 32'(cyc), 32'(n + 3));
                check(pc_out == exp_pc, "R6", "jump target", pc_out, exp_pc);
            end
            if (done) begin
                saw_done = 1;
                check(cyc == fin_cyc, jump ? "R6" : "R5", "done cycle",
                      32'(cyc), 32'(fin_cyc));
            end
        end
        start = 1'b0;
        check(saw_sp, "R5", "pointer written", 32'(saw_sp), 1);
        check(pops == n, "R7", "restore count", 32'(pops), 32'(n));
        @(negedge clk);
        check(!busy && !rf_we, "R8", "idle after done", 32'(busy), 0);
    endtask

    task automatic t_reset;
        check(!busy && !done, "R9", "busy/done after reset", {30'd0, busy, done}, 0);
        check(!rf_we && !mem_rd_en && !sp_we && !pc_we, "R9", "strobes after reset",
              {28'd0, rf_we, mem_rd_en, sp_we, pc_we}, 0);
    endtask

    task automatic t_plain_empty;      // R7 plain, no restores
        run_frame(16'h0640, 16'h0000, 32'h0000_8000, 1'b0);
    endtask

    task automatic t_plain_full;       // R3 R4 all twelve, largest adjust
        run_frame(16'h067F, 16'hFFE0, 32'h0001_0000, 1'b0);
    endtask

    task automatic t_plain_sparse;     // R4 mask 12'h805, adjust 3 words
        run_frame(16'h0647, 16'h00A0, 32'h0000_2004, 1'b0);
    endtask

    task automatic t_jump_outside;     // R6 target r5 not restored
        run_frame(16'h0644, 16'h1405, 32'h0000_3000, 1'b0);
    endtask

    task automatic t_jump_popped;      // R6 target r25 restored by the list
        run_frame(16'h0642, 16'h0439, 32'h0000_4010, 1'b0);
    endtask

    task automatic t_jump_empty;       // R7 jump form with no restores
        run_frame(16'h0640, 16'h001F, 32'h0000_5000, 1'b0);
    endtask

    task automatic t_restart;          // R8 start while busy
        run_frame(16'h0641, 16'hFFE0, 32'h0000_6000, 1'b1);
    endtask

    task automatic t_bad_opcode;       // R1 malformed first halfword
        logic seen;
        seen = 0;
        @(negedge clk);
        instr_hi = 16'h0A40;
        instr_lo = 16'hFFE0;
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 4; k++) begin
            if (busy || rf_we || sp_we || done) seen = 1;
            @(negedge clk);
        end
        check(!seen, "R1", "malformed opcode ignored", 32'(seen), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_plain_empty();
        t_plain_full();
        t_plain_sparse();
        t_jump_outside();
        t_jump_popped();
        t_jump_empty();
        t_restart();
        t_bad_opcode();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule